// File: doc/BRIEF.md
# Daisy-Chain Codec Configuration Sequencer

This block is the host side of a serial link to two codec serial ports that are wired in a daisy chain. After reset it uses three sampling events to configure both devices. Each event sends one pair of 16-bit control words that writes the same register in the two devices. The far device's word goes first and the near device's word follows, so both devices commit the register at the same moment. After the third pair the block streams samples. On each sampling event it sends a DAC word for each device, and it deserializes the ADC words that come back, tagging each with the device it belongs to.

The serial clock is the block clock: one bit moves per cycle on each line. A frame strobe marks the first bit of each word. The sequencer is a five-state machine:

- `ST_CFG_B` moves to `ST_CFG_C` on an accepted event.
- `ST_CFG_C` moves to `ST_CFG_A` on an accepted event.
- `ST_CFG_A` moves to `ST_DRAIN` on an accepted event.
- `ST_DRAIN` moves to `ST_STREAM` once the transmitter is idle.
- `ST_STREAM` stays where it is.

An event counts as accepted when the strobe is high, the transmitter is idle and the state is not `ST_DRAIN`.

Top module: `codec_chain_seq`

## Requirements
- R1: While reset is asserted and after it is released, `tx_fs`, `tx_sd`, `adc_valid` and `cfg_done` are all 0 until the first accepted event.
- R2: A control word is packed MSB first as follows:
  - bit 15 is the control flag, which is always 1;
  - bits 14:12 are the device address, 1 for the far device and 0 for the near device;
  - bits 11:9 are the register select;
  - bit 8 is 0;
  - bits 7:0 are the data byte.

  In every pair the far device's word is sent before the near device's word.
- R3: The configuration pairs go out on the first three accepted events, in this order:
  - register B (select 1) with data 8'h0F. This byte encodes a clock divide of 1 in bits 6:4, a serial clock of half the divided clock in bits 3:2 and a sample rate of the divided clock over 256 in bits 1:0.
  - register C (select 2) with data 8'h07. This byte powers the reference (bit 0), the ADC (bit 1) and the DAC (bit 2).
  - register A (select 0) with data 8'h05. This byte selects data mode (bit 0 = 1) and sets a device count of two (bits 3:1).
- R4: An accepted event in cycle t starts the pair in cycle t+1, and the pair takes 32 cycles in total.
  - `tx_fs` is high for exactly one cycle per word, on that word's first bit.
  - The second word's strobe comes exactly 16 cycles after the first, with no idle cycle between the words.
  - `tx_sd` is 0 while the line is idle.
- R5: A `sample_evt` that arrives while a pair is being sent, or while the state is `ST_DRAIN`, is ignored. It sends no word and does not advance the sequence.
- R6: `cfg_done` rises after the register A pair has been fully sent, with the transmitter idle. Once high it stays high.
- R7: In `ST_STREAM`, each accepted event sends `dac_far` and then `dac_near`, both sampled in the event cycle, as raw 16-bit words.
- R8: A receive word starts with `rx_fs` high on its MSB, and its remaining 15 bits follow on `rx_sd` in the next cycles. In the cycle after the last bit, `adc_valid` pulses for one cycle with the word on `adc_word`.
- R9: `adc_dev` reads 2 for the first received word after a `sample_evt` and 1 for the words after it. A word whose last bit shares a cycle with `sample_evt` counts as a first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_evt | input | 1 | Sampling-event strobe |
| dac_far | input | WORD_W | DAC word for the far device |
| dac_near | input | WORD_W | DAC word for the near device |
| tx_fs | output | 1 | Transmit frame strobe, high on each word's first bit |
| tx_sd | output | 1 | Transmit serial data, MSB first |
| rx_fs | input | 1 | Receive frame strobe, high on each word's first bit |
| rx_sd | input | 1 | Receive serial data, MSB first |
| adc_word | output | WORD_W | Last received ADC word |
| adc_valid | output | 1 | One-cycle pulse when `adc_word` is new |
| adc_dev | output | 2 | Device that produced `adc_word` (2 far, 1 near) |
| cfg_done | output | 1 | Configuration finished, streaming active |

## Verification
The checker watches the transmit strobe spacing on every cycle. The second strobe of a pair must land exactly sixteen cycles after the first, and it must never land early. On every cycle the checker also enforces that `cfg_done` is sticky and only rises on an idle line, that `adc_valid` is a single-cycle pulse, and that a near-device tag is never issued before a far-device word since the last event. Only the bench scenarios can show the bit content and order of each configuration word and each DAC word, and that the register B, C and A order is right. They also show that events arriving mid-pair or during the drain are dropped, and that the received words and their device tags match what was driven.

// File: rtl/codec_chain_pkg.sv
package codec_chain_pkg;

    typedef enum logic [2:0] {
        ST_CFG_B,
        ST_CFG_C,
        ST_CFG_A,
        ST_DRAIN,
        ST_STREAM
    } seq_state_t;

    localparam int CTL_W = 16;

    localparam logic [2:0] DEV_FAR  = 3'd1;
    localparam logic [2:0] DEV_NEAR = 3'd0;

    localparam logic [2:0] SEL_A = 3'd0;
    localparam logic [2:0] SEL_B = 3'd1;
    localparam logic [2:0] SEL_C = 3'd2;

    // B: divide code 0 (/1), serial clock code 3 (/2), rate code 3 (/256)
    localparam logic [7:0] BYTE_B = {1'b0, 3'd0, 2'd3, 2'd3};
    // C: DAC, ADC and reference powered
    localparam logic [7:0] BYTE_C = 8'h07;
    // A: device count 2, data mode
    localparam logic [7:0] BYTE_A = {4'd0, 3'd2, 1'b1};

    function automatic logic [CTL_W-1:0] ctl_word(input logic [2:0] dev,
                                                  input logic [2:0] sel,
                                                  input logic [7:0] val);
        return {1'b1, dev, sel, 1'b0, val};
    endfunction

endpackage

// File: rtl/codec_tx_ser.sv
module codec_tx_ser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [2*WORD_W-1:0] pair,
    output logic              busy,
    output logic              tx_fs,
    output logic              tx_sd
);
    localparam int PAIR_W = 2 * WORD_W;
    localparam int CNT_W  = $clog2(PAIR_W + 1);

    logic [PAIR_W-1:0] shreg;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
        end else if (load) begin
            shreg <= pair;
            left  <= CNT_W'(PAIR_W);
        end else if (left != '0) begin
            shreg <= shreg << 1;
            left  <= left - 1'b1;
        end
    end

    always_comb begin
        busy  = (left != '0);
        tx_sd = busy & shreg[PAIR_W-1];
        tx_fs = (left == CNT_W'(PAIR_W)) || (left == CNT_W'(WORD_W));
    end

endmodule

// File: rtl/codec_rx_deser.sv
module codec_rx_deser #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              rx_fs,
    input  logic              rx_sd,
    output logic [WORD_W-1:0] adc_word,
    output logic              adc_valid,
    output logic [1:0]        adc_dev
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              got_first;
    logic              is_first;

    assign is_first = restart | ~got_first;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            left      <= '0;
            got_first <= 1'b0;
            adc_word  <= '0;
            adc_valid <= 1'b0;
            adc_dev   <= 2'd0;
        end else begin
            adc_valid <= 1'b0;
            if (rx_fs) begin
                shreg <= {shreg[WORD_W-3:0], rx_sd};
                left  <= CNT_W'(WORD_W - 1);
            end else if (left != '0) begin
                shreg <= {shreg[WORD_W-3:0], rx_sd};
                left  <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    adc_valid <= 1'b1;
                    adc_word  <= {shreg, rx_sd};
                    adc_dev   <= is_first ? 2'd2 : 2'd1;
                    got_first <= 1'b1;
                end
            end
            if (restart) begin
                got_first <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/codec_seq_fsm.sv
module codec_seq_fsm
    import codec_chain_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_evt,
    input  logic                tx_busy,
    input  logic [WORD_W-1:0]   dac_far,
    input  logic [WORD_W-1:0]   dac_near,
    output logic                load,
    output logic [2*WORD_W-1:0] pair,
    output logic                cfg_done
);
    localparam int PAD = WORD_W - CTL_W;

    seq_state_t state, state_nx;
    logic       accept;

    function automatic logic [WORD_W-1:0] widen(input logic [CTL_W-1:0] c);
        return WORD_W'(c) << PAD;
    endfunction

    assign accept = sample_evt & ~tx_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CFG_B;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CFG_B:  if (accept)   state_nx = ST_CFG_C;
            ST_CFG_C:  if (accept)   state_nx = ST_CFG_A;
            ST_CFG_A:  if (accept)   state_nx = ST_DRAIN;
            ST_DRAIN:  if (!tx_busy) state_nx = ST_STREAM;
            ST_STREAM: state_nx = ST_STREAM;
            default:   state_nx = ST_CFG_B;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        pair     = '0;
        cfg_done = 1'b0;
        unique case (state)
            ST_CFG_B: begin
                load = accept;
                pair = {widen(ctl_word(DEV_FAR, SEL_B, BYTE_B)),
                        widen(ctl_word(DEV_NEAR, SEL_B, BYTE_B))};
            end
            ST_CFG_C: begin
                load = accept;
                pair = {widen(ctl_word(DEV_FAR, SEL_C, BYTE_C)),
                        widen(ctl_word(DEV_NEAR, SEL_C, BYTE_C))};
            end
            ST_CFG_A: begin
                load = accept;
                pair = {widen(ctl_word(DEV_FAR, SEL_A, BYTE_A)),
                        widen(ctl_word(DEV_NEAR, SEL_A, BYTE_A))};
            end
            ST_DRAIN: begin
                load = 1'b0;
            end
            ST_STREAM: begin
                load     = accept;
                pair     = {dac_far, dac_near};
                cfg_done = 1'b1;
            end
            default: load = 1'b0;
        endcase
    end

endmodule

// File: rtl/codec_chain_seq.sv
module codec_chain_seq #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_evt,
    input  logic [WORD_W-1:0] dac_far,
    input  logic [WORD_W-1:0] dac_near,
    output logic              tx_fs,
    output logic              tx_sd,
    input  logic              rx_fs,
    input  logic              rx_sd,
    output logic [WORD_W-1:0] adc_word,
    output logic              adc_valid,
    output logic [1:0]        adc_dev,
    output logic              cfg_done
);
    logic                load;
    logic                tx_busy;
    logic [2*WORD_W-1:0] pair;

    codec_seq_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_evt (sample_evt),
        .tx_busy    (tx_busy),
        .dac_far    (dac_far),
        .dac_near   (dac_near),
        .load       (load),
        .pair       (pair),
        .cfg_done   (cfg_done)
    );

    codec_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .pair  (pair),
        .busy  (tx_busy),
        .tx_fs (tx_fs),
        .tx_sd (tx_sd)
    );

    codec_rx_deser #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (sample_evt),
        .rx_fs     (rx_fs),
        .rx_sd     (rx_sd),
        .adc_word  (adc_word),
        .adc_valid (adc_valid),
        .adc_dev   (adc_dev)
    );

endmodule

// File: rtl/codec_chain_chk.sv
module codec_chain_chk #(
    parameter int WORD_W = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_evt,
    input logic       tx_fs,
    input logic       adc_valid,
    input logic [1:0] adc_dev,
    input logic       cfg_done
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic             half;
    logic [CNT_W-1:0] gap_cnt;
    logic             seen_far;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half     <= 1'b0;
            gap_cnt  <= '0;
            seen_far <= 1'b0;
        end else begin
            if (tx_fs) begin
                half    <= ~half;
                gap_cnt <= '0;
            end else if (gap_cnt != CNT_W'(WORD_W)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (sample_evt)                         seen_far <= 1'b0;
            else if (adc_valid && adc_dev == 2'd2)  seen_far <= 1'b1;
        end
    end

    AST_PAIR_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        half && !tx_fs && gap_cnt == CNT_W'(WORD_W - 2) |=> tx_fs); // R4

    AST_PAIR_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        half && tx_fs |-> gap_cnt == CNT_W'(WORD_W - 1)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> !tx_fs && !half); // R6

    AST_ADC_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |=> !adc_valid); // R8

    AST_ADC_DEV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> (adc_dev == 2'd2 || adc_dev == 2'd1)); // R9

    AST_ADC_NEAR_AFTER_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid && adc_dev == 2'd1 |-> seen_far); // R9

endmodule

bind codec_chain_seq codec_chain_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_evt (sample_evt),
    .tx_fs      (tx_fs),
    .adc_valid  (adc_valid),
    .adc_dev    (adc_dev),
    .cfg_done   (cfg_done)
);

// File: tb/tb_codec_chain_seq.sv
module tb_codec_chain_seq;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sample_evt = 1'b0;
    logic [W-1:0] dac_far = '0;
    logic [W-1:0] dac_near = '0;
    logic         rx_fs = 1'b0;
    logic         rx_sd = 1'b0;
    logic         tx_fs, tx_sd, adc_valid, cfg_done;
    logic [W-1:0] adc_word;
    logic [1:0]   adc_dev;

    int checks = 0;
    int failures = 0;

    logic [15:0] exp_tx[$];
    string       exp_tag[$];
    logic [17:0] exp_rx[$];

    codec_chain_seq #(.WORD_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt),
        .dac_far(dac_far), .dac_near(dac_near),
        .tx_fs(tx_fs), .tx_sd(tx_sd), .rx_fs(rx_fs), .rx_sd(rx_sd),
        .adc_word(adc_word), .adc_valid(adc_valid), .adc_dev(adc_dev),
        .cfg_done(cfg_done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] dev, input logic [2:0] sel,
                                       input logic [7:0] val);
        return {1'b1, dev, sel, 1'b0, val};
    endfunction

    task automatic send_event(input bit accepted, input logic [15:0] wf,
                              input logic [15:0] wn, input string tag);
        @(negedge clk);
        sample_evt = 1'b1;
        if (accepted) begin
            exp_tx.push_back(wf); exp_tag.push_back(tag);
            exp_tx.push_back(wn); exp_tag.push_back(tag);
        end
        @(negedge clk);
        sample_evt = 1'b0;
        if (accepted) check(tx_fs == 1'b1, "R4", "first strobe one cycle after event", tx_fs, 1);
    endtask

    task automatic rx_send(input logic [15:0] w, input logic [1:0] dev);
        exp_rx.push_back({dev, w});
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            rx_fs = (i == W - 1);
            rx_sd = w[i];
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_fs = 1'b0;
        rx_sd = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // transmit monitor
    int          bits_left = 0;
    int          wpos = 0;
    int          idle_cnt = 0;
    logic [15:0] acc = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_fs) begin
                check(bits_left == 0, "R4", "strobe inside a word", bits_left, 0);
                if (wpos == 1) check(idle_cnt == 0, "R4", "gap inside pair", idle_cnt, 0);
                acc = {15'd0, tx_sd};
                bits_left = 15;
            end else if (bits_left > 0) begin
                acc = {acc[14:0], tx_sd};
                bits_left--;
                if (bits_left == 0) begin
                    if (exp_tx.size() == 0) begin
                        check(1'b0, "R5", "unexpected transmit word", acc, 0);
                    end else begin
                        automatic logic [15:0] e = exp_tx.pop_front();
                        automatic string t = exp_tag.pop_front();
                        check(acc == e, t, "transmit word", acc, e);
                    end
                    wpos = 1 - wpos;
                    idle_cnt = 0;
                end
            end else begin
                idle_cnt++;
                if (tx_sd !== 1'b0) check(1'b0, "R4", "idle line data", tx_sd, 0);
            end
        end
    end

    // receive monitor
    always @(negedge clk) begin
        if (rst_n && adc_valid) begin
            if (exp_rx.size() == 0) begin
                check(1'b0, "R8", "unexpected adc_valid", {adc_dev, adc_word}, 0);
            end else begin
                automatic logic [17:0] e = exp_rx.pop_front();
                check(adc_word == e[15:0], "R8", "adc word", adc_word, e[15:0]);
                check(adc_dev == e[17:16], "R9", "adc device index", adc_dev, e[17:16]);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_fs == 1'b0, "R1", "tx_fs in reset", tx_fs, 0);
        check(tx_sd == 1'b0, "R1", "tx_sd in reset", tx_sd, 0);
        check(adc_valid == 1'b0, "R1", "adc_valid in reset", adc_valid, 0);
        check(cfg_done == 1'b0, "R1", "cfg_done in reset", cfg_done, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_fs == 1'b0 && cfg_done == 1'b0, "R1", "idle after reset", {tx_fs, cfg_done}, 0);

        // configuration: B, C, A (R2, R3)
        send_event(1'b1, mk(3'd1, 3'd1, 8'h0F), mk(3'd0, 3'd1, 8'h0F), "R3");
        idle(40);
        check(cfg_done == 1'b0, "R6", "done low after B", cfg_done, 0);
        send_event(1'b1, mk(3'd1, 3'd2, 8'h07), mk(3'd0, 3'd2, 8'h07), "R3");
        idle(40);
        check(cfg_done == 1'b0, "R6", "done low after C", cfg_done, 0);
        send_event(1'b1, mk(3'd1, 3'd0, 8'h05), mk(3'd0, 3'd0, 8'h05), "R2");
        repeat (6) @(negedge clk);
        send_event(1'b0, '0, '0, "R5");   // dropped mid-pair (R5)
        check(cfg_done == 1'b0, "R6", "done low during A pair", cfg_done, 0);
        repeat (22) @(negedge clk);
        send_event(1'b0, '0, '0, "R5");   // dropped in drain window (R5)
        idle(10);
        check(cfg_done == 1'b1, "R6", "done high after A pair", cfg_done, 1);

        // streaming with back-to-back receive words (R7, R8, R9)
        for (int k = 0; k < 4; k++) begin
            dac_far  = 16'hA5C3 ^ (16'h1111 * k);
            dac_near = 16'h0F0F + (16'h0123 * k);
            send_event(1'b1, dac_far, dac_near, "R7");
            rx_send(16'h8001 + 16'(k), 2'd2);
            rx_send(16'h7FFE - 16'(k), 2'd1);
            idle(20);
        end
        check(cfg_done == 1'b1, "R6", "done stays high", cfg_done, 1);

        // event during a streaming pair is dropped (R5)
        dac_far = 16'h1234; dac_near = 16'hFEDC;
        send_event(1'b1, dac_far, dac_near, "R7");
        repeat (4) @(negedge clk);
        dac_far = 16'hDEAD; dac_near = 16'hBEEF;
        send_event(1'b0, '0, '0, "R5");
        idle(40);

        // receive words with a gap keep the index (R9)
        send_event(1'b1, dac_far, dac_near, "R7");
        rx_send(16'hFFFF, 2'd2);
        idle(5);
        rx_send(16'h0000, 2'd1);
        idle(30);

        // a new event restarts the index (R9)
        send_event(1'b1, dac_far, dac_near, "R7");
        rx_send(16'h5555, 2'd2);
        idle(25);
        send_event(1'b1, dac_far, dac_near, "R7");
        rx_send(16'hAAAA, 2'd2);
        rx_send(16'h3C3C, 2'd1);
        idle(50);

        check(exp_tx.size() == 0, "R2", "all transmit words seen", exp_tx.size(), 0);
        check(exp_rx.size() == 0, "R8", "all receive words seen", exp_rx.size(), 0);
        finish_run();
    end

endmodule